// File: doc/BRIEF.md
# PLL Self-Calibration Sequencer

This block decides when a clock-multiplier loop has to run its internal calibration and then supervises the run. A calibration is requested by a power-on reset, by the release of the external active-low reset pin, by any change on the configuration-select pins, by an out-of-range report from the loop registers, or by the selected input frequency moving 500 ppm or more away from the value recorded at the last completed calibration. A request is acted on only when the selected input clock shows no alarm and a reference clock is present. Until then the controller waits.

Once the calibration completes, the loop is reported locked and no further calibration runs until a new trigger arrives. If the input clock alarms while locked, the controller goes to holdover. When the alarm clears, it goes straight back to locked without calibrating. The loss-of-lock alarm is raised in every state except locked, and so it covers the whole calibration. The analog loop, its calibration algorithm and the frequency counter are outside the block. They appear only as the strobe, flag and count inputs.

Top module: `pll_cal_sequencer`

## Requirements
- R1: While `porPulse` is high and on the cycle after it, the outputs read `lossOfLock`=1, `locked`=0, `holdover`=0 and `calStart`=0.
- R2: While `rstPinN` is low (after a two-flop synchroniser), the controller stays in reset and issues no `calStart`. A low-to-high transition requests a calibration. With valid clocks, `calStart` is seen on the 4th rising edge after the pin rises.
- R3: Any change of `cfgPins` requests a calibration. With valid clocks, `calStart` is seen on the 4th rising edge after the change.
- R4: A one-cycle `loopOutOfRange` pulse requests a calibration. With valid clocks, `calStart` follows on the 2nd rising edge.
- R5: A pending calibration starts only on an edge where the previous cycle had `inClkAlarm`=0 and `refPresent`=1. Otherwise the controller waits, with `lossOfLock`=1.
- R6: `calStart` is a single-cycle pulse issued on entry to calibration, and `lossOfLock` is 1 throughout calibration.
- R7: `calDone` during calibration gives `locked`=1 on the next edge and records `freqCount`. No further `calStart` occurs without a new trigger.
- R8: While locked, `inClkAlarm`=1 gives `holdover` on the next edge. When the alarm clears, `locked` returns on the next edge with no `calStart`.
- R9: While locked, if |`freqCount` − recorded| × 2000 ≥ recorded, a calibration is requested and `lossOfLock` rises on the next edge. Smaller differences have no effect.
- R10: A configuration change that is detected during calibration aborts it. Calibration restarts, with a new `calStart`, once the clocks are valid.
- R11: `locked` is high only in the locked state and `holdover` only in holdover. `lossOfLock` equals the inverse of `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| porPulse | input | 1 | Power-on reset, active high, synchronous |
| rstPinN | input | 1 | External reset pin, active low, asynchronous to clk |
| cfgPins | input | CFG_W | Frequency/table/bandwidth/crystal-select pins |
| loopOutOfRange | input | 1 | Loop registers out of range |
| inClkAlarm | input | 1 | Alarm on the selected input clock |
| refPresent | input | 1 | Reference clock present |
| freqCount | input | CNT_W | Measured count of the selected input frequency |
| calDone | input | 1 | Calibration finished strobe from the loop |
| calStart | output | 1 | One-cycle calibration start command |
| lossOfLock | output | 1 | Loss-of-lock alarm |
| holdover | output | 1 | Holdover indication |
| locked | output | 1 | Locked indication |

## Verification
The outputs decode the state register, so each result is due a fixed number of edges after its stimulus. The pin and configuration triggers pass through the synchroniser and reach the waiting state on the 3rd edge and `calStart` on the 4th. The out-of-range and drift triggers act on the 1st edge, and `calDone`, the alarm and its clearing act on the 1st edge. The bench drives on falling edges, advances exactly that many rising edges and samples on the following falling edge. It also counts `calStart` pulses, to prove that none appear where a requirement forbids them. A sweep of frequency offsets on both sides of the 500 ppm threshold compares against |d|·2000 ≥ ref, computed in the bench.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [4:0] {
    ST_RESET    = 5'b00001,
    ST_WAITCLK  = 5'b00010,
    ST_CAL      = 5'b00100,
    ST_LOCKED   = 5'b01000,
    ST_HOLDOVER = 5'b10000
  } calState_t;

  // control -> datapath
  typedef struct packed {
    logic latchFreq;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic rstHeld;
    logic rstRise;
    logic cfgChange;
    logic outOfRange;
    logic driftTrip;
  } dpEvent_t;

endpackage

// File: rtl/cal_seq_datapath.sv
module cal_seq_datapath
  import cal_seq_pkg::*;
#(
  parameter int CFG_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             porPulse,
  input  logic             rstPinN,
  input  logic [CFG_W-1:0] cfgPins,
  input  logic             loopOutOfRange,
  input  logic [CNT_W-1:0] freqCount,
  input  ctrlStrobe_t      strobe,
  output dpEvent_t         events
);

  // diff * 2000 = diff*2048 - diff*32 - diff*16
  localparam int SW = CNT_W + 11;

  logic             rstS1, rstS2, rstPrev;
  logic [CFG_W-1:0] cfgS1, cfgS2, cfgPrev;
  logic [1:0]       primeCnt;
  logic [CNT_W-1:0] freqRef;
  logic             refValid;
  logic [CNT_W-1:0] diff;
  logic [SW-1:0]    diffExt, scaled;

  always_ff @(posedge clk) begin
    if (porPulse) begin
      rstS1    <= 1'b0;
      rstS2    <= 1'b0;
      rstPrev  <= 1'b0;
      cfgS1    <= '0;
      cfgS2    <= '0;
      cfgPrev  <= '0;
      primeCnt <= '0;
    end else begin
      rstS1   <= rstPinN;
      rstS2   <= rstS1;
      rstPrev <= rstS2;
      cfgS1   <= cfgPins;
      cfgS2   <= cfgS1;
      cfgPrev <= cfgS2;
      if (primeCnt != 2'd3) primeCnt <= primeCnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (porPulse) begin
      freqRef  <= '0;
      refValid <= 1'b0;
    end else if (strobe.latchFreq) begin
      freqRef  <= freqCount;
      refValid <= 1'b1;
    end
  end

  always_comb begin
    diff    = (freqCount >= freqRef) ? (freqCount - freqRef) : (freqRef - freqCount);
    diffExt = SW'(diff);
    scaled  = (diffExt << 11) - (diffExt << 5) - (diffExt << 4);
  end

  assign events.rstHeld    = ~rstS2;
  assign events.rstRise    = rstS2 & ~rstPrev;
  assign events.cfgChange  = (primeCnt == 2'd3) && (cfgS2 != cfgPrev);
  assign events.outOfRange = loopOutOfRange;
  assign events.driftTrip  = refValid && (scaled >= SW'(freqRef));

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic        clk,
  input  logic        porPulse,
  input  dpEvent_t    events,
  input  logic        inClkAlarm,
  input  logic        refPresent,
  input  logic        calDone,
  output ctrlStrobe_t strobe,
  output logic        calStart,
  output logic        lossOfLock,
  output logic        holdover,
  output logic        locked
);

  calState_t state, nxt;
  logic      clkOk, trig;

  assign clkOk = ~inClkAlarm & refPresent;
  assign trig  = events.rstRise | events.cfgChange | events.outOfRange;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:    if (!events.rstHeld) nxt = ST_WAITCLK;
      ST_WAITCLK:  if (clkOk) nxt = ST_CAL;
      ST_CAL: begin
        if (trig || !clkOk) nxt = ST_WAITCLK;
        else if (calDone)   nxt = ST_LOCKED;
      end
      ST_LOCKED: begin
        if (trig || events.driftTrip) nxt = ST_WAITCLK;
        else if (inClkAlarm)          nxt = ST_HOLDOVER;
      end
      ST_HOLDOVER: begin
        if (trig)             nxt = ST_WAITCLK;
        else if (!inClkAlarm) nxt = ST_LOCKED;
      end
      default: nxt = ST_RESET;
    endcase
    if (events.rstHeld) nxt = ST_RESET;
  end

  assign strobe.latchFreq = (state == ST_CAL) && (nxt == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (porPulse) begin
      state    <= ST_RESET;
      calStart <= 1'b0;
    end else begin
      state    <= nxt;
      calStart <= (nxt == ST_CAL) && (state != ST_CAL);
    end
  end

  assign locked     = state[3];
  assign holdover   = state[4];
  assign lossOfLock = ~state[3];

endmodule

// File: rtl/pll_cal_sequencer.sv
module pll_cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int CFG_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             porPulse,
  input  logic             rstPinN,
  input  logic [CFG_W-1:0] cfgPins,
  input  logic             loopOutOfRange,
  input  logic             inClkAlarm,
  input  logic             refPresent,
  input  logic [CNT_W-1:0] freqCount,
  input  logic             calDone,
  output logic             calStart,
  output logic             lossOfLock,
  output logic             holdover,
  output logic             locked
);

  ctrlStrobe_t strobe;
  dpEvent_t    events;

  cal_seq_datapath #(.CFG_W(CFG_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .porPulse(porPulse), .rstPinN(rstPinN), .cfgPins(cfgPins),
    .loopOutOfRange(loopOutOfRange), .freqCount(freqCount),
    .strobe(strobe), .events(events)
  );

  cal_seq_ctrl uCtrl (
    .clk(clk), .porPulse(porPulse), .events(events),
    .inClkAlarm(inClkAlarm), .refPresent(refPresent), .calDone(calDone),
    .strobe(strobe), .calStart(calStart), .lossOfLock(lossOfLock),
    .holdover(holdover), .locked(locked)
  );

endmodule

// File: rtl/pll_cal_sequencer_chk.sv
module pll_cal_sequencer_chk (
  input logic clk,
  input logic porPulse,
  input logic inClkAlarm,
  input logic refPresent,
  input logic calDone,
  input logic calStart,
  input logic lossOfLock,
  input logic holdover,
  input logic locked
);

  // R5
  start_needs_clk_chk: assert property (@(posedge clk) disable iff (porPulse)
    calStart |-> $past(!inClkAlarm && refPresent));

  // R6
  lol_in_cal_chk: assert property (@(posedge clk) disable iff (porPulse)
    calStart |-> lossOfLock);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (porPulse)
    calStart |=> !calStart);

  // R7
  lock_source_chk: assert property (@(posedge clk) disable iff (porPulse)
    $rose(locked) |-> ($past(calDone) || $past(holdover)));

  // R8
  holdover_entry_chk: assert property (@(posedge clk) disable iff (porPulse)
    $rose(holdover) |-> $past(inClkAlarm));

  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (porPulse)
    !(locked && (holdover || lossOfLock)));

endmodule

bind pll_cal_sequencer pll_cal_sequencer_chk uChk (
  .clk(clk), .porPulse(porPulse), .inClkAlarm(inClkAlarm),
  .refPresent(refPresent), .calDone(calDone), .calStart(calStart),
  .lossOfLock(lossOfLock), .holdover(holdover), .locked(locked)
);

// File: tb/tb_pll_cal_sequencer.sv
module tb_pll_cal_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 6;
  localparam int CNT_W = 16;
  localparam int REF_F = 20000;

  logic             clk = 1'b0;
  logic             porPulse = 1'b1;
  logic             rstPinN = 1'b0;
  logic [CFG_W-1:0] cfgPins = '0;
  logic             loopOutOfRange = 1'b0;
  logic             inClkAlarm = 1'b1;
  logic             refPresent = 1'b0;
  logic [CNT_W-1:0] freqCount = CNT_W'(REF_F);
  logic             calDone = 1'b0;
  logic             calStart, lossOfLock, holdover, locked;

  int checks = 0;
  int failures = 0;
  int startCnt = 0;
  bit done = 1'b0;

  pll_cal_sequencer #(.CFG_W(CFG_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .porPulse(porPulse), .rstPinN(rstPinN), .cfgPins(cfgPins),
    .loopOutOfRange(loopOutOfRange), .inClkAlarm(inClkAlarm),
    .refPresent(refPresent), .freqCount(freqCount), .calDone(calDone),
    .calStart(calStart), .lossOfLock(lossOfLock), .holdover(holdover),
    .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (calStart === 1'b1) startCnt++;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input int st, input int lol, input int hold, input int lk);
    check({req, " calStart"}, int'(calStart), st);
    check({req, " lossOfLock"}, int'(lossOfLock), lol);
    check({req, " holdover"}, int'(holdover), hold);
    check({req, " locked"}, int'(locked), lk);
  endtask

  task automatic finishCal();
    calDone = 1'b1;
    tick(1);
    calDone = 1'b0;
  endtask

  initial begin
    int base;
    @(negedge clk);
    tick(3);
    checkOut("R1 during por", 0, 1, 0, 0);
    porPulse = 1'b0;
    tick(1);
    checkOut("R1 after por", 0, 1, 0, 0);
    tick(5);
    check("R2 pin low no start", startCnt, 0);
    checkOut("R2 pin low", 0, 1, 0, 0);

    // release pin with clocks invalid: must wait
    rstPinN = 1'b1;
    tick(6);
    checkOut("R5 alarm wait", 0, 1, 0, 0);
    refPresent = 1'b1;
    tick(3);
    check("R5 no start with alarm", startCnt, 0);
    inClkAlarm = 1'b0;
    tick(1);
    checkOut("R5 R6 start on valid", 1, 1, 0, 0);
    tick(1);
    checkOut("R6 pulse ends, cal lol", 0, 1, 0, 0);
    finishCal();
    checkOut("R7 locked", 0, 0, 0, 1);
    base = startCnt;
    tick(10);
    check("R7 no recal", startCnt, base);

    // holdover
    inClkAlarm = 1'b1;
    tick(1);
    checkOut("R8 R11 holdover", 0, 1, 1, 0);
    tick(3);
    inClkAlarm = 1'b0;
    tick(1);
    checkOut("R8 relock", 0, 0, 0, 1);
    tick(3);
    check("R8 no cal on relock", startCnt, base);

    // out of range
    loopOutOfRange = 1'b1;
    tick(1);
    loopOutOfRange = 1'b0;
    checkOut("R4 wait", 0, 1, 0, 0);
    tick(1);
    checkOut("R4 start", 1, 1, 0, 0);
    finishCal();
    check("R4 relock", int'(locked), 1);

    // config change
    cfgPins = 6'd1;
    tick(3);
    checkOut("R3 wait", 0, 1, 0, 0);
    tick(1);
    checkOut("R3 start", 1, 1, 0, 0);
    // change during calibration
    cfgPins = 6'd2;
    tick(3);
    checkOut("R10 aborted", 0, 1, 0, 0);
    tick(1);
    checkOut("R10 restart", 1, 1, 0, 0);
    finishCal();
    check("R10 relock", int'(locked), 1);

    // drift sweep, ref = REF_F
    for (int d = -12; d <= 12; d++) begin
      int ad;
      int trip;
      ad = (d < 0) ? -d : d;
      trip = (ad * 2000 >= REF_F) ? 1 : 0;
      freqCount = CNT_W'(REF_F + d);
      tick(1);
      check($sformatf("R9 drift d=%0d lol", d), int'(lossOfLock), trip);
      if (trip == 1) begin
        tick(1);
        check($sformatf("R9 drift d=%0d start", d), int'(calStart), 1);
        freqCount = CNT_W'(REF_F);
        finishCal();
        check($sformatf("R9 drift d=%0d relock", d), int'(locked), 1);
      end else begin
        freqCount = CNT_W'(REF_F);
      end
    end

    // pin reset while locked
    rstPinN = 1'b0;
    tick(3);
    checkOut("R2 reset held", 0, 1, 0, 0);
    tick(4);
    rstPinN = 1'b1;
    tick(3);
    checkOut("R2 released wait", 0, 1, 0, 0);
    tick(1);
    checkOut("R2 release start", 1, 1, 0, 0);
    finishCal();
    check("R2 relock", int'(locked), 1);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule